// File: doc/BRIEF.md
# Dataway Cycle Sequencer with Repeat Modes

This block turns host commands into timed bus cycles on a crate dataway. A command names a station N, a sub-address A and a function code F. Each cycle drives the address and function in a setup phase, raises a first strobe (S1), then a second strobe (S2), then releases the bus. Read data from the dataway is captured during S1. Write data is driven from setup until S2 ends.

Besides single cycles, three repeat modes are supported. A software repeat pulse, given while idle, runs one more cycle at the next address. A hardware repeat runs a preloaded number of complete cycles and steps the address between them. A fast repeat keeps the address fixed and issues only the S1 strobe again, until the cycle counter is used up, and then closes with a single S2. A busy flag covers the whole sequence, and a one-clock done pulse marks its end. Indicator outputs show the current address and function for a front-panel display.

Top module: `dwy_cycle_seq`

## Requirements
- R1: After reset, busy, done, both strobes, read-valid and the indicator outputs are all zero.
- R2: A single command (mode 2'b00, or the unused code 2'b11) runs one cycle. Setup lasts T_SETUP clocks, S1 lasts T_S1, S2 lasts T_S2 and release lasts T_REL, in that order. Busy is high for exactly their sum, and done pulses for one clock on the first idle cycle.
- R3: S1 and S2 are never high together, and neither is high while busy is low.
- R4: When F[4:3]=2'b00 (a read function), the dataway read data is captured on the last clock of every S1, and read-valid pulses once per S1. Other functions capture nothing.
- R5: When F[4:3]=2'b10 (a write function), the write data is driven from the start of setup to the end of S2 and is held stable. At all other times, and for other functions, the write-data output is zero.
- R6: A software repeat pulse while idle runs one cycle with the same F, at the address that follows the last one used.
- R7: An address step adds one to A (4 bits). When A wraps from 15 to 0, N (5 bits) increments, and N returns to 1 after N_MAX (24).
- R8: Hardware repeat (mode 2'b01) with count n>0 runs n complete cycles and steps the address before each cycle after the first. A count of 0 runs one cycle.
- R9: Fast repeat (mode 2'b10) with count n>0 issues n S1 strobes at a fixed address. The strobes are separated by T_GAP low clocks and followed by one S2. A count of 0 gives one S1.
- R10: Commands and software repeat pulses arriving while busy are ignored. They change neither the running sequence nor anything after it.
- R11: The indicator outputs show the N, A and F of the current cycle from the clock after acceptance, and keep the last values while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, accepted when idle |
| cmd_n_i | input | 5 | Station number |
| cmd_a_i | input | 4 | Sub-address |
| cmd_f_i | input | 5 | Function code |
| cmd_mode_i | input | 2 | 00 single, 01 hardware repeat, 10 fast repeat |
| cmd_count_i | input | CNT_W | Cycle count for the repeat modes |
| cmd_wdata_i | input | DW | Write data |
| sw_rep_i | input | 1 | Software repeat request |
| dw_rdata_i | input | DW | Read data from the dataway |
| dw_n_o | output | 5 | Station driven on the dataway while busy |
| dw_a_o | output | 4 | Sub-address driven while busy |
| dw_f_o | output | 5 | Function driven while busy |
| dw_wdata_o | output | DW | Write data driven on the dataway |
| dw_s1_o | output | 1 | First strobe |
| dw_s2_o | output | 1 | Second strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock end-of-sequence pulse |
| rdata_o | output | DW | Last captured read data |
| rdata_valid_o | output | 1 | Pulses after each capture |
| disp_n_o | output | 5 | Indicator: station |
| disp_a_o | output | 4 | Indicator: sub-address |
| disp_f_o | output | 5 | Indicator: function |

## Verification
The bench builds the block with T_SETUP=2, T_S1=3, T_GAP=1, T_S2=2, T_REL=1 and CNT_W=6. The phase lengths are all short and three of them differ. A swapped or mis-timed phase therefore changes the strobe start offsets and the total busy length, which the bench computes from these values. The short phases also keep a five-strobe fast run and a four-cycle hardware run brief. With them, both the A wrap and the N wrap from 24 back to 1 can be reached in a two-cycle hardware repeat.

// File: rtl/dwy_pkg.sv
package dwy_pkg;
  localparam int N_W = 5;
  localparam int A_W = 4;
  localparam int F_W = 5;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_S1, PH_GAP, PH_S2, PH_REL} phase_e;
  typedef enum logic [1:0] {MD_SINGLE = 2'b00, MD_HW = 2'b01, MD_FAST = 2'b10, MD_RSVD = 2'b11} mode_e;

  typedef struct packed {
    logic [N_W-1:0] n;
    logic [A_W-1:0] a;
  } addr_t;
endpackage

// File: rtl/dwy_phase_timer.sv
module dwy_phase_timer import dwy_pkg::*; #(
  parameter int TW      = 3,
  parameter int T_SETUP = 2,
  parameter int T_S1    = 3,
  parameter int T_GAP   = 2,
  parameter int T_S2    = 3,
  parameter int T_REL   = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  output logic   phase_end_o
);
  logic [TW-1:0] cnt_q, lim;

  always_comb begin
    unique case (phase_i)
      PH_SETUP: lim = TW'(T_SETUP);
      PH_S1:    lim = TW'(T_S1);
      PH_GAP:   lim = TW'(T_GAP);
      PH_S2:    lim = TW'(T_S2);
      PH_REL:   lim = TW'(T_REL);
      default:  lim = TW'(1);
    endcase
  end

  assign phase_end_o = (phase_i != PH_IDLE) && (cnt_q == lim - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (phase_i == PH_IDLE || phase_end_o) cnt_q <= '0;
    else cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/dwy_addr_step.sv
module dwy_addr_step import dwy_pkg::*; #(
  parameter int N_MAX = 24
) (
  input  addr_t cur_i,
  output addr_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.a == '1) begin
      nxt_o.a = '0;
      nxt_o.n = (cur_i.n >= N_W'(N_MAX)) ? N_W'(1) : cur_i.n + N_W'(1);
    end else begin
      nxt_o.a = cur_i.a + A_W'(1);
    end
  end
endmodule

// File: rtl/dwy_cycle_seq.sv
module dwy_cycle_seq import dwy_pkg::*; #(
  parameter int DW      = 24,
  parameter int CNT_W   = 8,
  parameter int N_MAX   = 24,
  parameter int T_SETUP = 2,
  parameter int T_S1    = 3,
  parameter int T_GAP   = 2,
  parameter int T_S2    = 3,
  parameter int T_REL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [4:0]       cmd_n_i,
  input  logic [3:0]       cmd_a_i,
  input  logic [4:0]       cmd_f_i,
  input  logic [1:0]       cmd_mode_i,
  input  logic [CNT_W-1:0] cmd_count_i,
  input  logic [DW-1:0]    cmd_wdata_i,
  input  logic             sw_rep_i,
  input  logic [DW-1:0]    dw_rdata_i,
  output logic [4:0]       dw_n_o,
  output logic [3:0]       dw_a_o,
  output logic [4:0]       dw_f_o,
  output logic [DW-1:0]    dw_wdata_o,
  output logic             dw_s1_o,
  output logic             dw_s2_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rdata_valid_o,
  output logic [4:0]       disp_n_o,
  output logic [3:0]       disp_a_o,
  output logic [4:0]       disp_f_o
);
  localparam int T_M1  = (T_SETUP > T_S1) ? T_SETUP : T_S1;
  localparam int T_M2  = (T_GAP > T_S2) ? T_GAP : T_S2;
  localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M3 > T_REL) ? T_M3 : T_REL;
  localparam int TW    = $clog2(T_MAX + 1);

  phase_e           st_q;
  mode_e            md_q, md_in;
  addr_t            cur_q, nxt;
  logic [F_W-1:0]   f_q;
  logic [DW-1:0]    wd_q, rd_q;
  logic [CNT_W-1:0] rem_q, cnt_in;
  logic             done_q, rv_q, pend, rd_fn, wr_fn, wd_phase;

  dwy_phase_timer #(
    .TW(TW), .T_SETUP(T_SETUP), .T_S1(T_S1), .T_GAP(T_GAP), .T_S2(T_S2), .T_REL(T_REL)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(st_q), .phase_end_o(pend)
  );

  dwy_addr_step #(.N_MAX(N_MAX)) u_step (.cur_i(cur_q), .nxt_o(nxt));

  assign md_in  = mode_e'(cmd_mode_i);
  // plain modes and a zero count both collapse to one cycle
  assign cnt_in = (md_in == MD_SINGLE || md_in == MD_RSVD || cmd_count_i == '0)
                  ? CNT_W'(1) : cmd_count_i;
  assign rd_fn  = (f_q[4:3] == 2'b00);
  assign wr_fn  = (f_q[4:3] == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      md_q   <= MD_SINGLE;
      cur_q  <= '0;
      f_q    <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (cmd_valid_i) begin
            cur_q <= '{n: cmd_n_i, a: cmd_a_i};
            f_q   <= cmd_f_i;
            wd_q  <= cmd_wdata_i;
            md_q  <= md_in;
            rem_q <= cnt_in;
            st_q  <= PH_SETUP;
          end else if (sw_rep_i) begin
            cur_q <= nxt;
            md_q  <= MD_SINGLE;
            rem_q <= CNT_W'(1);
            st_q  <= PH_SETUP;
          end
        end
        PH_SETUP: if (pend) st_q <= PH_S1;
        PH_S1: if (pend) begin
          if (rd_fn) begin
            rd_q <= dw_rdata_i;
            rv_q <= 1'b1;
          end
          if (md_q == MD_FAST && rem_q > CNT_W'(1)) begin
            rem_q <= rem_q - CNT_W'(1);
            st_q  <= PH_GAP;
          end else begin
            st_q  <= PH_S2;
          end
        end
        PH_GAP: if (pend) st_q <= PH_S1;
        PH_S2:  if (pend) st_q <= PH_REL;
        PH_REL: if (pend) begin
          if (md_q == MD_HW && rem_q > CNT_W'(1)) begin
            rem_q <= rem_q - CNT_W'(1);
            cur_q <= nxt;
            st_q  <= PH_SETUP;
          end else begin
            done_q <= 1'b1;
            st_q   <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != PH_IDLE);
  assign dw_s1_o       = (st_q == PH_S1);
  assign dw_s2_o       = (st_q == PH_S2);
  assign wd_phase      = (st_q == PH_SETUP) || (st_q == PH_S1) || (st_q == PH_GAP) || (st_q == PH_S2);
  assign dw_wdata_o    = (wr_fn && wd_phase) ? wd_q : '0;
  assign dw_n_o        = busy_o ? cur_q.n : '0;
  assign dw_a_o        = busy_o ? cur_q.a : '0;
  assign dw_f_o        = busy_o ? f_q : '0;
  assign done_o        = done_q;
  assign rdata_o       = rd_q;
  assign rdata_valid_o = rv_q;
  assign disp_n_o      = cur_q.n;
  assign disp_a_o      = cur_q.a;
  assign disp_f_o      = f_q;
endmodule

// File: rtl/dwy_cycle_seq_chk.sv
module dwy_cycle_seq_chk #(
  parameter int DW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dw_s1_o,
  input logic          dw_s2_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          rdata_valid_o,
  input logic [4:0]    disp_f_o,
  input logic [DW-1:0] dw_wdata_o
);
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dw_s1_o && dw_s2_o));

  p_strobe_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_s1_o || dw_s2_o) |-> busy_o);

  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_capture_on_s1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o |-> $past(dw_s1_o));

  p_func_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(disp_f_o));

  p_wdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dw_s2_o && $past(dw_s2_o)) |-> $stable(dw_wdata_o));
endmodule

bind dwy_cycle_seq dwy_cycle_seq_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dw_s1_o(dw_s1_o), .dw_s2_o(dw_s2_o),
  .busy_o(busy_o), .done_o(done_o), .rdata_valid_o(rdata_valid_o),
  .disp_f_o(disp_f_o), .dw_wdata_o(dw_wdata_o)
);

// File: tb/tb_dwy_cycle_seq.sv
module tb_dwy_cycle_seq;
  localparam int DW = 24, CNT_W = 6;
  localparam int T_SETUP = 2, T_S1 = 3, T_GAP = 1, T_S2 = 2, T_REL = 1;
  localparam int T_CYC = T_SETUP + T_S1 + T_S2 + T_REL;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, sw_rep = 0;
  logic [4:0] cmd_n = 0, cmd_f = 0;
  logic [3:0] cmd_a = 0;
  logic [1:0] cmd_mode = 0;
  logic [CNT_W-1:0] cmd_count = 0;
  logic [DW-1:0] cmd_wdata = 0, dw_rdata, dw_wdata, rdata;
  logic [4:0] dw_n, dw_f, disp_n, disp_f;
  logic [3:0] dw_a, disp_a;
  logic s1, s2, busy, done, rvalid;

  always #10 clk = ~clk;

  assign dw_rdata = {15'h0, dw_n, dw_a};

  dwy_cycle_seq #(
    .DW(DW), .CNT_W(CNT_W), .N_MAX(24),
    .T_SETUP(T_SETUP), .T_S1(T_S1), .T_GAP(T_GAP), .T_S2(T_S2), .T_REL(T_REL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_n_i(cmd_n),
    .cmd_a_i(cmd_a), .cmd_f_i(cmd_f), .cmd_mode_i(cmd_mode), .cmd_count_i(cmd_count),
    .cmd_wdata_i(cmd_wdata), .sw_rep_i(sw_rep), .dw_rdata_i(dw_rdata),
    .dw_n_o(dw_n), .dw_a_o(dw_a), .dw_f_o(dw_f), .dw_wdata_o(dw_wdata),
    .dw_s1_o(s1), .dw_s2_o(s2), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .rdata_valid_o(rvalid), .disp_n_o(disp_n), .disp_a_o(disp_a), .disp_f_o(disp_f)
  );

  int n_chk = 0, n_fail = 0;
  int busy_cyc, done_cnt, s1_cnt, s2_cnt, s1_hi, rv_cnt, wd_err, wd_hi;
  int first_s1_at, first_s2_at;
  logic [DW-1:0] exp_wd, last_rd;
  logic [4:0] n_log [64];
  logic [3:0] a_log [64];
  logic [4:0] f_log [64];
  logic s1_prev = 0, s2_prev = 0;

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (done) done_cnt++;
    if (s1 && !s1_prev) begin
      if (s1_cnt == 0) first_s1_at = busy_cyc;
      if (s1_cnt < 64) begin
        n_log[s1_cnt] = dw_n; a_log[s1_cnt] = dw_a; f_log[s1_cnt] = dw_f;
      end
      s1_cnt++;
    end
    if (s2 && !s2_prev) begin
      if (s2_cnt == 0) first_s2_at = busy_cyc;
      s2_cnt++;
    end
    if (s1) s1_hi++;
    if (rvalid) begin rv_cnt++; last_rd = rdata; end
    if ((s1 || s2) && dw_wdata != exp_wd) wd_err++;
    if (!busy && dw_wdata != '0) wd_err++;
    if (dw_wdata != '0) wd_hi++;
    s1_prev = s1; s2_prev = s2;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    busy_cyc = 0; done_cnt = 0; s1_cnt = 0; s2_cnt = 0; s1_hi = 0;
    rv_cnt = 0; wd_err = 0; wd_hi = 0; first_s1_at = -1; first_s2_at = -1;
  endtask

  task automatic issue(input int n, input int a, input int f, input int md, input int cnt, input logic [DW-1:0] wd);
    @(negedge clk);
    cmd_n = 5'(n); cmd_a = 4'(a); cmd_f = 5'(f); cmd_mode = 2'(md);
    cmd_count = CNT_W'(cnt); cmd_wdata = wd; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_rep = 1;
    @(negedge clk); sw_rep = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (done_cnt > 0) break;
      @(negedge clk);
    end
    if (done_cnt == 0) chk("R2", "done timeout", 0, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int n, input int a, input int f, input int md, input int cnt, input logic [DW-1:0] wd);
    clear_mon();
    exp_wd = (5'(f) >> 3 == 5'b10) ? wd : '0;
    issue(n, a, f, md, cnt, wd);
    wait_done();
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "strobes", {s1, s2}, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rvalid", rvalid, 0);
    chk("R1", "disp", {disp_n, disp_a, disp_f}, 0);
  endtask

  task automatic t_single_read();
    run(3, 2, 0, 0, 0, '0);
    chk("R2", "s1 pulses", s1_cnt, 1);
    chk("R2", "s2 pulses", s2_cnt, 1);
    chk("R2", "busy length", busy_cyc, T_CYC);
    chk("R2", "s1 start", first_s1_at, T_SETUP + 1);
    chk("R2", "s2 start", first_s2_at, T_SETUP + T_S1 + 1);
    chk("R2", "s1 width", s1_hi, T_S1);
    chk("R2", "done pulses", done_cnt, 1);
    chk("R4", "read captures", rv_cnt, 1);
    chk("R4", "read data", last_rd, {15'h0, 5'd3, 4'd2});
    chk("R11", "disp", {disp_n, disp_a, disp_f}, {5'd3, 4'd2, 5'd0});
    chk("R5", "wdata idle for read", wd_err + wd_hi, 0);
  endtask

  task automatic t_single_write();
    run(7, 1, 16, 3, 9, 24'hA5C3E1);
    chk("R2", "reserved mode one cycle", s1_cnt, 1);
    chk("R4", "no capture on write", rv_cnt, 0);
    chk("R5", "wdata mismatches", wd_err, 0);
    chk("R5", "wdata driven clocks", wd_hi, T_SETUP + T_S1 + T_S2);
  endtask

  task automatic t_sw_repeat();
    run(5, 15, 2, 0, 0, '0);
    clear_mon();
    exp_wd = '0;
    pulse_sw();
    wait_done();
    chk("R6", "sw repeat cycles", s1_cnt, 1);
    chk("R6", "sw repeat busy", busy_cyc, T_CYC);
    chk("R7", "sw repeat N", n_log[0], 6);
    chk("R7", "sw repeat A", a_log[0], 0);
    chk("R6", "sw repeat F", f_log[0], 2);
  endtask

  task automatic t_hw_repeat();
    run(2, 14, 0, 1, 4, '0);
    chk("R8", "hw cycles", s1_cnt, 4);
    chk("R8", "hw s2", s2_cnt, 4);
    chk("R8", "hw busy", busy_cyc, 4 * T_CYC);
    chk("R8", "hw done", done_cnt, 1);
    chk("R7", "addr0", {n_log[0], a_log[0]}, {5'd2, 4'd14});
    chk("R7", "addr1", {n_log[1], a_log[1]}, {5'd2, 4'd15});
    chk("R7", "addr2", {n_log[2], a_log[2]}, {5'd3, 4'd0});
    chk("R7", "addr3", {n_log[3], a_log[3]}, {5'd3, 4'd1});
    chk("R4", "hw captures", rv_cnt, 4);
    chk("R11", "disp hold", {disp_n, disp_a}, {5'd3, 4'd1});
  endtask

  task automatic t_n_wrap();
    run(24, 15, 1, 1, 2, '0);
    chk("R7", "wrap first", {n_log[0], a_log[0]}, {5'd24, 4'd15});
    chk("R7", "wrap second", {n_log[1], a_log[1]}, {5'd1, 4'd0});
  endtask

  task automatic t_hw_zero();
    run(10, 3, 0, 1, 0, '0);
    chk("R8", "hw zero cycles", s1_cnt, 1);
    chk("R8", "hw zero busy", busy_cyc, T_CYC);
  endtask

  task automatic t_fast();
    run(4, 6, 0, 2, 5, '0);
    chk("R9", "fast s1", s1_cnt, 5);
    chk("R9", "fast s2", s2_cnt, 1);
    chk("R9", "fast busy", busy_cyc, T_SETUP + 5 * T_S1 + 4 * T_GAP + T_S2 + T_REL);
    chk("R9", "fast s1 width", s1_hi, 5 * T_S1);
    chk("R9", "fast addr first", {n_log[0], a_log[0]}, {5'd4, 4'd6});
    chk("R9", "fast addr last", {n_log[4], a_log[4]}, {5'd4, 4'd6});
    chk("R4", "fast captures", rv_cnt, 5);
  endtask

  task automatic t_fast_zero();
    run(4, 6, 0, 2, 0, '0);
    chk("R9", "fast zero s1", s1_cnt, 1);
    chk("R9", "fast zero busy", busy_cyc, T_CYC);
  endtask

  task automatic t_busy_ignore();
    clear_mon();
    exp_wd = '0;
    issue(8, 0, 0, 1, 3, '0);
    repeat (4) @(negedge clk);
    issue(20, 9, 16, 0, 0, 24'h123456);
    repeat (3) @(negedge clk);
    pulse_sw();
    wait_done();
    chk("R10", "cycles while busy", s1_cnt, 3);
    chk("R10", "addr0", {n_log[0], a_log[0], f_log[0]}, {5'd8, 4'd0, 5'd0});
    chk("R10", "addr2", {n_log[2], a_log[2]}, {5'd8, 4'd2});
    chk("R10", "busy total", busy_cyc, 3 * T_CYC);
    chk("R10", "wdata untouched", wd_err + wd_hi, 0);
    repeat (10) @(negedge clk);
    chk("R10", "no late start", busy_cyc, 3 * T_CYC);
    chk("R11", "disp after", {disp_n, disp_a}, {5'd8, 4'd2});
  endtask

  initial begin
    clear_mon();
    exp_wd = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_single_read();
    t_single_write();
    t_sw_repeat();
    t_hw_repeat();
    t_n_wrap();
    t_hw_zero();
    t_fast();
    t_fast_zero();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule